// File: doc/BRIEF.md
# EEPROM Program-Cycle Status Read Responder

This block answers host reads while the memory's internal program cycle is in progress. When the write engine reports that programming is under way, a read no longer returns array contents. It returns a status word instead. That word carries two indicators on every byte lane. One is the complement of the most significant bit of the byte that was last loaded into that lane. The other is a bit that changes value on each successive read. Software can poll either indicator until the cycle ends. Once the busy indication drops, reads pass the array data through again.

The block also models the open-drain ready/busy pin. The output is an enable that pulls the shared line low; the pin's data value is fixed at zero, so several devices can share one wired-OR line. The enable is set by the first write strobe of a cycle and released when the engine's busy indication falls. All outputs are registered. The read result appears in the cycle after the read strobe and is held until the next strobe.

Top module: `eeprom_status_resp`

## Requirements
- R1: After synchronous reset, `rd_data` is zero, `rdy_pull_oe` is 0, and the first status read that follows returns 1 in bit 6 of every lane.
- R2: A read strobe while `prog_busy` is low loads `rd_data` with `array_rdata` on the next clock edge.
- R3: A read strobe while `prog_busy` is high sets bit 8k+7 of `rd_data` to the inverse of bit 8k+7 of `last_load` for each lane k.
- R4: During a busy period, bit 6 of every lane is 1 on the first status read and alternates on each later status read.
- R5: In a status read, every bit other than bits 7 and 6 of each lane is zero, whatever `array_rdata` holds.
- R6: Cycles without a read strobe leave the toggle state unchanged; the next status read continues the alternation.
- R7: A write strobe sets `rdy_pull_oe` on the next edge. This also holds when `prog_busy` falls in the same cycle.
- R8: When `prog_busy` goes from high to low and there is no write strobe in that cycle, `rdy_pull_oe` clears on the next edge. While `prog_busy` stays high, `rdy_pull_oe` stays set.
- R9: After a busy period ends, reads return array data again, and the next busy period restarts the toggle bit at 1.
- R10: `rd_data` holds its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_busy | input | 1 | High while the write engine is loading or programming |
| wr_strobe | input | 1 | One-cycle pulse for each host write |
| rd_strobe | input | 1 | One-cycle pulse for each host read |
| last_load | input | 32 | Last byte loaded on each lane, as kept by the write engine |
| array_rdata | input | 32 | Array read data |
| rd_data | output | 32 | Registered read result (array data or status word) |
| rdy_pull_oe | output | 1 | 1 pulls the open-drain ready/busy line low; 0 leaves it high-impedance |

## Verification
The assertions assume the following about the inputs:
- `prog_busy`, `wr_strobe` and `rd_strobe` are synchronous single-bit levels that carry no unknown values once reset is released.
- `last_load` is stable in the cycle a status read is sampled.

The bench follows these assumptions. It changes every input on the falling clock edge only, and it holds `prog_busy` low during reset. Each busy period is started and ended by explicit vectors, so every edge of `prog_busy` is deliberate. The stimulus includes the case where a write strobe coincides with the end of a busy period.

// File: rtl/eesr_pkg.sv
package eesr_pkg;

    parameter int unsigned LANES    = 4;
    parameter int unsigned BYTE_W   = 8;
    parameter int unsigned POLL_BIT = 7;
    parameter int unsigned TGL_BIT  = 6;
    localparam int unsigned DATA_W  = LANES * BYTE_W;

    typedef logic [DATA_W-1:0] word_t;

    // Source selected for a read result
    typedef enum logic [1:0] {
        SRC_HOLD   = 2'd0,
        SRC_ARRAY  = 2'd1,
        SRC_STATUS = 2'd2
    } rd_src_e;

    typedef struct packed {
        logic busy;
        logic rd;
        logic wr;
    } host_ctl_t;

    function automatic rd_src_e pick_source(host_ctl_t c);
        if (!c.rd)
            return SRC_HOLD;
        return c.busy ? SRC_STATUS : SRC_ARRAY;
    endfunction

endpackage

// File: rtl/esr_toggle.sv
module esr_toggle (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic rd_strobe,
    output logic tgl
);
    // Starts at 1 for each busy period and flips only on a completed read.
    always_ff @(posedge clk) begin
        if (rst)
            tgl <= 1'b1;
        else if (!busy)
            tgl <= 1'b1;
        else if (rd_strobe)
            tgl <= ~tgl;
    end
endmodule

// File: rtl/esr_rdy_ctl.sv
module esr_rdy_ctl (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic wr_strobe,
    output logic pull_oe
);
    logic busy_q;
    logic busy_end;

    assign busy_end = busy_q & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            pull_oe <= 1'b0;
        end else begin
            busy_q <= busy;
            if (wr_strobe)
                pull_oe <= 1'b1;
            else if (busy_end)
                pull_oe <= 1'b0;
        end
    end
endmodule

// File: rtl/esr_lane_status.sv
module esr_lane_status #(
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned POLL_BIT = 7,
    parameter int unsigned TGL_BIT  = 6
) (
    input  logic [BYTE_W-1:0] last_byte,
    input  logic              tgl,
    output logic [BYTE_W-1:0] status
);
    always_comb begin
        status           = '0;
        status[POLL_BIT] = ~last_byte[POLL_BIT];
        status[TGL_BIT]  = tgl;
    end
endmodule

// File: rtl/esr_read_reg.sv
module esr_read_reg #(
    parameter int unsigned DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  eesr_pkg::rd_src_e    src,
    input  logic [DATA_W-1:0]    array_word,
    input  logic [DATA_W-1:0]    status_word,
    output logic [DATA_W-1:0]    q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else begin
            case (src)
                eesr_pkg::SRC_ARRAY:  q <= array_word;
                eesr_pkg::SRC_STATUS: q <= status_word;
                default:              q <= q;
            endcase
        end
    end
endmodule

// File: rtl/eeprom_status_resp.sv
module eeprom_status_resp #(
    parameter int unsigned LANES    = eesr_pkg::LANES,
    parameter int unsigned BYTE_W   = eesr_pkg::BYTE_W,
    parameter int unsigned POLL_BIT = eesr_pkg::POLL_BIT,
    parameter int unsigned TGL_BIT  = eesr_pkg::TGL_BIT,
    localparam int unsigned DATA_W  = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_busy,
    input  logic              wr_strobe,
    input  logic              rd_strobe,
    input  logic [DATA_W-1:0] last_load,
    input  logic [DATA_W-1:0] array_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rdy_pull_oe
);
    import eesr_pkg::*;

    logic              tgl;
    logic [DATA_W-1:0] status_word;
    host_ctl_t         ctl;
    rd_src_e           src;

    assign ctl = '{busy: prog_busy, rd: rd_strobe, wr: wr_strobe};
    assign src = pick_source(ctl);

    esr_toggle u_toggle (
        .clk       (clk),
        .rst       (rst),
        .busy      (ctl.busy),
        .rd_strobe (ctl.rd),
        .tgl       (tgl)
    );

    esr_rdy_ctl u_rdy (
        .clk       (clk),
        .rst       (rst),
        .busy      (ctl.busy),
        .wr_strobe (ctl.wr),
        .pull_oe   (rdy_pull_oe)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        esr_lane_status #(
            .BYTE_W   (BYTE_W),
            .POLL_BIT (POLL_BIT),
            .TGL_BIT  (TGL_BIT)
        ) u_lane (
            .last_byte (last_load[k*BYTE_W +: BYTE_W]),
            .tgl       (tgl),
            .status    (status_word[k*BYTE_W +: BYTE_W])
        );
    end

    esr_read_reg #(.DATA_W(DATA_W)) u_rreg (
        .clk         (clk),
        .rst         (rst),
        .src         (src),
        .array_word  (array_rdata),
        .status_word (status_word),
        .q           (rd_data)
    );
endmodule

// File: rtl/eeprom_status_resp_chk.sv
module eeprom_status_resp_chk #(
    parameter int unsigned LANES    = 4,
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned POLL_BIT = 7,
    parameter int unsigned TGL_BIT  = 6,
    localparam int unsigned DATA_W  = LANES * BYTE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              prog_busy,
    input logic              wr_strobe,
    input logic              rd_strobe,
    input logic [DATA_W-1:0] last_load,
    input logic [DATA_W-1:0] array_rdata,
    input logic [DATA_W-1:0] rd_data,
    input logic              rdy_pull_oe
);
    function automatic logic [DATA_W-1:0] mask_of(int unsigned pos);
        logic [DATA_W-1:0] m = '0;
        for (int k = 0; k < int'(LANES); k++)
            m[k*BYTE_W + pos] = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] POLL_M = mask_of(POLL_BIT);
    localparam logic [DATA_W-1:0] TGL_M  = mask_of(TGL_BIT);

    p_idle_read_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !prog_busy) |=> (rd_data == $past(array_rdata)));

    p_poll_bits_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && prog_busy) |=> (((rd_data ^ ~$past(last_load)) & POLL_M) == '0));

    p_first_tgl_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(prog_busy) && rd_strobe) |=> ((rd_data & TGL_M) == TGL_M));

    p_zero_rest_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && prog_busy) |=> ((rd_data & ~(POLL_M | TGL_M)) == '0));

    p_rdy_set_r7: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |=> rdy_pull_oe);

    p_rdy_clr_r8: assert property (@(posedge clk) disable iff (rst)
        (!prog_busy && $past(prog_busy) && !wr_strobe) |=> !rdy_pull_oe);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe |=> $stable(rd_data));
endmodule

bind eeprom_status_resp eeprom_status_resp_chk #(
    .LANES    (LANES),
    .BYTE_W   (BYTE_W),
    .POLL_BIT (POLL_BIT),
    .TGL_BIT  (TGL_BIT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .prog_busy   (prog_busy),
    .wr_strobe   (wr_strobe),
    .rd_strobe   (rd_strobe),
    .last_load   (last_load),
    .array_rdata (array_rdata),
    .rd_data     (rd_data),
    .rdy_pull_oe (rdy_pull_oe)
);

// File: tb/eeprom_status_resp_tb.sv
module eeprom_status_resp_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_busy = 1'b0;
    logic        wr_strobe = 1'b0;
    logic        rd_strobe = 1'b0;
    logic [31:0] last_load = '0;
    logic [31:0] array_rdata = '0;
    logic [31:0] rd_data;
    logic        rdy_pull_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    eeprom_status_resp u_dut (
        .clk         (clk),
        .rst         (rst),
        .prog_busy   (prog_busy),
        .wr_strobe   (wr_strobe),
        .rd_strobe   (rd_strobe),
        .last_load   (last_load),
        .array_rdata (array_rdata),
        .rd_data     (rd_data),
        .rdy_pull_oe (rdy_pull_oe)
    );

    typedef struct packed {
        logic        busy;
        logic        wr;
        logic        rd;
        logic [31:0] ld;
        logic [31:0] arr;
        logic [31:0] exp_data;
        logic        exp_rdy;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        // R2: idle read passes array data
        '{1'b0, 1'b0, 1'b1, 32'h0, 32'hA5A5_1234, 32'hA5A5_1234, 1'b0, 8'd2},
        // R7 and R10: write sets the pull-down, data held
        '{1'b0, 1'b1, 1'b0, 32'h0, 32'h1111_1111, 32'hA5A5_1234, 1'b1, 8'd7},
        // R3, R4 and R5: first status read, mixed poll bits, toggle 1
        '{1'b1, 1'b0, 1'b1, 32'h8000_8000, 32'hDEAD_BEEF, 32'h40C0_40C0, 1'b1, 8'd3},
        // R6: no read, value held
        '{1'b1, 1'b0, 1'b0, 32'h8000_8000, 32'hDEAD_BEEF, 32'h40C0_40C0, 1'b1, 8'd6},
        // R4 and R6: second read gives toggle 0
        '{1'b1, 1'b0, 1'b1, 32'h8000_8000, 32'hDEAD_BEEF, 32'h0080_0080, 1'b1, 8'd4},
        // R3: all MSBs set, toggle 1 again
        '{1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h4040_4040, 1'b1, 8'd3},
        // R8: busy falls, pull-down released
        '{1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h4040_4040, 1'b0, 8'd8},
        // R9: array data again
        '{1'b0, 1'b0, 1'b1, 32'h0, 32'h0BAD_F00D, 32'h0BAD_F00D, 1'b0, 8'd9},
        // R9: new busy period restarts toggle at 1
        '{1'b1, 1'b1, 1'b1, 32'h0, 32'h1234_5678, 32'hC0C0_C0C0, 1'b1, 8'd9},
        // R4: alternation
        '{1'b1, 1'b0, 1'b1, 32'h0, 32'h1234_5678, 32'h8080_8080, 1'b1, 8'd4},
        // R7: write in the same cycle as busy end keeps pull-down
        '{1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 32'h8080_8080, 1'b1, 8'd7},
        // R8: no further busy end, stays set
        '{1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h8080_8080, 1'b1, 8'd8},
        // R8: held while busy high
        '{1'b1, 1'b0, 1'b0, 32'h0, 32'h0, 32'h8080_8080, 1'b1, 8'd8},
        // R8: busy end clears
        '{1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h8080_8080, 1'b0, 8'd8}
    };

    task automatic check(input string req, input logic [31:0] got_d,
                         input logic [31:0] exp_d, input logic got_r,
                         input logic exp_r);
        n_checks++;
        if (got_d !== exp_d || got_r !== exp_r) begin
            n_fail++;
            $display("FAIL %s: rd_data=%h rdy=%b expected rd_data=%h rdy=%b",
                     req, got_d, got_r, exp_d, exp_r);
        end
    endtask

    task automatic drive(input logic b, input logic w, input logic r,
                         input logic [31:0] ld, input logic [31:0] arr);
        prog_busy   = b;
        wr_strobe   = w;
        rd_strobe   = r;
        last_load   = ld;
        array_rdata = arr;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", rd_data, 32'h0, rdy_pull_oe, 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].busy, VEC[i].wr, VEC[i].rd, VEC[i].ld, VEC[i].arr);
            check($sformatf("R%0d", VEC[i].req), rd_data, VEC[i].exp_data,
                  rdy_pull_oe, VEC[i].exp_rdy);
        end

        // R1: reset in the middle of a busy period, after toggle moved
        drive(1'b1, 1'b1, 1'b1, 32'h0, 32'h0);
        prog_busy = 1'b0;
        wr_strobe = 1'b0;
        rd_strobe = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R1", rd_data, 32'h0, rdy_pull_oe, 1'b0);
        rst = 1'b0;
        // R1: first status read after reset has toggle 1 on all lanes
        drive(1'b1, 1'b0, 1'b1, 32'h8080_8080, 32'hFFFF_FFFF);
        check("R1", rd_data, 32'h4040_4040, rdy_pull_oe, 1'b0);
        // R5: status read ignores array data, R6: idle cycles keep toggle
        drive(1'b1, 1'b0, 1'b0, 32'h8080_8080, 32'hFFFF_FFFF);
        drive(1'b1, 1'b0, 1'b0, 32'h8080_8080, 32'hFFFF_FFFF);
        check("R10", rd_data, 32'h4040_4040, rdy_pull_oe, 1'b0);
        drive(1'b1, 1'b0, 1'b1, 32'h8080_8080, 32'hFFFF_FFFF);
        check("R6", rd_data, 32'h0000_0000, rdy_pull_oe, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 32'h0, 32'h0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule